// File: doc/BRIEF.md
# Pipelined Wallace Tree Multiplier

This block multiplies two unsigned operands and returns the full-width product. Each partial-product row is formed by ANDing the multiplicand with one bit of the multiplier and shifting it left by that bit's position. The rows are then compressed, three at a time, by columns of full adder cells until only two rows remain. A carry-propagate adder built from one half adder and a ripple of full adders sums those two rows.

A register bank sits in front of every level of adder cells. A new operand pair can therefore enter on every clock, and each product leaves after a fixed number of cycles. That number equals the count of compression levels, which is four at the default 8-bit width.

A valid strobe travels alongside the data through the same registers, and results leave in the order the operands entered. The block has no stall input. The consumer must take each product in the cycle it is flagged.

Top module: `wt_mult_pipe`

## Requirements
- R1: For every operand pair accepted with `op_vld` high, `prod` equals the exact unsigned product `op_a * op_b`, computed at 2*WIDTH bits with no truncation.
- R2: The latency in clock edges equals the number of Wallace levels needed to reduce WIDTH rows to two. Each level maps n rows to 2*floor(n/3) + (n mod 3). This gives 4 edges for WIDTH=8 (8,6,4,3,2) and 2 edges for WIDTH=4 (4,3,2). A pair sampled at edge k is presented after edge k+latency-1.
- R3: `prod_vld` is high in exactly the cycles that correspond, one latency earlier, to edges where `op_vld` was sampled high. Cycles where `op_vld` was low yield no valid output.
- R4: Operand pairs may be presented on consecutive cycles with no gap, and the products emerge in the order the pairs entered.
- R5: While `rst_n` is low, `prod_vld` is low, and every valid bit in the pipeline is cleared. After release, no valid output appears until a pair sampled after the release has crossed the pipeline.
- R6: At WIDTH=8, 0x0F x 0xFA gives 0x0EA6, 0xF0 x 0xFF gives 0xEF10, 0x5A x 0xF0 gives 0x5460, and 0x00 x 0xF0 gives 0x0000.
- R7: A zero operand gives a zero product, and two all-ones operands give (2^WIDTH-1)^2. At WIDTH=8 that value is 0xFE01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| op_a | input | WIDTH | Multiplicand |
| op_b | input | WIDTH | Multiplier |
| op_vld | input | 1 | Operand pair valid, sampled on each rising edge |
| prod | output | 2*WIDTH | Unsigned product |
| prod_vld | output | 1 | Product valid |

## Verification
The bench builds two copies of the block. One uses the default WIDTH=8 and has a four-level tree. The other uses WIDTH=4 and has a two-level tree, which shows that the level count and the latency follow the parameter.

At WIDTH=8, all 65,536 operand pairs are streamed back to back. This reaches every carry path through the full adder columns and the ripple adder, and it exercises ordering under a full pipeline. The narrow copy is swept exhaustively twice, once back to back and once with periodic bubbles in `op_vld`. A reset asserted in the middle of a stream shows that partly filled stages are discarded.

// File: rtl/wt_pkg.sv
package wt_pkg;

  // rows left after one level of 3:2 compression
  function automatic int wt_next_rows(int n);
    return 2 * (n / 3) + (n % 3);
  endfunction

  // rows present at the input of level lvl (lvl 0 = partial products)
  function automatic int wt_rows_at(int w, int lvl);
    int n;
    n = w;
    for (int i = 0; i < lvl; i++) n = wt_next_rows(n);
    return n;
  endfunction

  // number of levels until two rows remain
  function automatic int wt_levels(int w);
    int n;
    int c;
    n = w;
    c = 0;
    for (int i = 0; i < 64; i++) begin
      if (n > 2) begin
        n = wt_next_rows(n);
        c++;
      end
    end
    return c;
  endfunction

  // first row index of level lvl inside the flattened row chain
  function automatic int wt_row_base(int w, int lvl);
    int s;
    s = 0;
    for (int i = 0; i < lvl; i++) s += wt_rows_at(w, i);
    return s;
  endfunction

endpackage

// File: rtl/wt_cells.sv
module wt_ha (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  assign s  = a ^ b;
  assign co = a & b;
endmodule

module wt_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = a ^ b ^ ci;
  assign co = (a & b) | (ci & (a ^ b));
endmodule

// File: rtl/wt_csa_level.sv
// One Wallace level: every full group of three rows becomes a sum row and a
// carry row shifted up by one; the one or two rows left over pass through.
module wt_csa_level #(
  parameter int PW  = 16,
  parameter int NIN = 8,
  localparam int NGRP = NIN / 3,
  localparam int NLEFT = NIN % 3,
  localparam int NOUT = 2 * NGRP + NLEFT
) (
  input  logic [NIN*PW-1:0]  rows_i,
  output logic [NOUT*PW-1:0] rows_o
);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [PW-1:0] x, y, z;
    logic [PW-1:0] s_row;
    logic [PW-2:0] c_row;
    assign x = rows_i[(3*g)*PW   +: PW];
    assign y = rows_i[(3*g+1)*PW +: PW];
    assign z = rows_i[(3*g+2)*PW +: PW];
    for (genvar i = 0; i < PW - 1; i++) begin : g_bit
      wt_fa u_fa (.a(x[i]), .b(y[i]), .ci(z[i]), .s(s_row[i]), .co(c_row[i]));
    end
    // the top column only needs its sum: a carry out of it would leave the product width
    assign s_row[PW-1] = x[PW-1] ^ y[PW-1] ^ z[PW-1];
    assign rows_o[(2*g)*PW   +: PW] = s_row;
    assign rows_o[(2*g+1)*PW +: PW] = {c_row, 1'b0};
  end

  for (genvar j = 0; j < NLEFT; j++) begin : g_pass
    assign rows_o[(2*NGRP+j)*PW +: PW] = rows_i[(3*NGRP+j)*PW +: PW];
  end

endmodule

// File: rtl/wt_stage.sv
// Register bank in front of one level of adder cells.
module wt_stage #(
  parameter int PW  = 16,
  parameter int NIN = 8,
  localparam int NOUT = wt_pkg::wt_next_rows(NIN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vld_i,
  input  logic [NIN*PW-1:0]  rows_i,
  output logic               vld_o,
  output logic [NOUT*PW-1:0] rows_o
);

  logic              vld_d, vld_q;
  logic [NIN*PW-1:0] rows_d, rows_q;

  // next state: data advances only with a valid token
  always_comb begin
    vld_d  = vld_i;
    rows_d = vld_i ? rows_i : rows_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    rows_q <= rows_d;
  end

  wt_csa_level #(.PW(PW), .NIN(NIN)) u_lvl (.rows_i(rows_q), .rows_o(rows_o));

  assign vld_o = vld_q;

endmodule

// File: rtl/wt_cpa.sv
// Final carry-propagate adder: half adder at bit 0, ripple of full adders above.
module wt_cpa #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  output logic [PW-1:0] sum
);

  logic [PW-2:0] c;

  wt_ha u_ha0 (.a(x[0]), .b(y[0]), .s(sum[0]), .co(c[0]));

  for (genvar i = 1; i < PW - 1; i++) begin : g_rip
    wt_fa u_fa (.a(x[i]), .b(y[i]), .ci(c[i-1]), .s(sum[i]), .co(c[i]));
  end

  assign sum[PW-1] = x[PW-1] ^ y[PW-1] ^ c[PW-2];

endmodule

// File: rtl/wt_mult_pipe.sv
module wt_mult_pipe #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  input  logic               op_vld,
  output logic [2*WIDTH-1:0] prod,
  output logic               prod_vld
);

  localparam int PW     = 2 * WIDTH;
  localparam int NLVL   = wt_pkg::wt_levels(WIDTH);
  localparam int NROWS  = wt_pkg::wt_row_base(WIDTH, NLVL + 1);
  localparam int LASTB  = wt_pkg::wt_row_base(WIDTH, NLVL);

  // all row sets of all levels, flattened one after the other
  logic [NROWS*PW-1:0] chain;
  logic [NLVL:0]       vld;

  // partial products: row i is op_a gated by op_b[i], shifted up by i
  for (genvar i = 0; i < WIDTH; i++) begin : g_pp
    logic [PW-1:0] wide_a;
    assign wide_a = {{WIDTH{1'b0}}, op_a & {WIDTH{op_b[i]}}};
    assign chain[i*PW +: PW] = wide_a << i;
  end
  assign vld[0] = op_vld;

  for (genvar s = 0; s < NLVL; s++) begin : g_stg
    localparam int NIN  = wt_pkg::wt_rows_at(WIDTH, s);
    localparam int NOUT = wt_pkg::wt_rows_at(WIDTH, s + 1);
    localparam int BIN  = wt_pkg::wt_row_base(WIDTH, s);
    localparam int BOUT = wt_pkg::wt_row_base(WIDTH, s + 1);
    wt_stage #(.PW(PW), .NIN(NIN)) u_stg (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (vld[s]),
      .rows_i (chain[BIN*PW  +: NIN*PW]),
      .vld_o  (vld[s+1]),
      .rows_o (chain[BOUT*PW +: NOUT*PW])
    );
  end

  wt_cpa #(.PW(PW)) u_cpa (
    .x   (chain[LASTB*PW +: PW]),
    .y   (chain[(LASTB+1)*PW +: PW]),
    .sum (prod)
  );

  assign prod_vld = vld[NLVL];

endmodule

// File: rtl/wt_mult_pipe_chk.sv
module wt_mult_pipe_chk #(
  parameter int WIDTH = 8,
  parameter int LAT   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic               op_vld,
  input logic [2*WIDTH-1:0] prod,
  input logic               prod_vld
);

  // edges seen since reset release, saturating at LAT
  int age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 0;
    else if (age < LAT)  age <= age + 1;
  end

  // R1
  prod_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prod_vld |-> prod == ((2*WIDTH)'($past(op_a, LAT)) * (2*WIDTH)'($past(op_b, LAT))));

  // R1
  prod_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prod_vld |-> !$isunknown(prod));

  // R3
  vld_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == LAT) |-> (prod_vld == $past(op_vld, LAT)));

  // R5
  rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age < LAT) |-> !prod_vld);

endmodule

bind wt_mult_pipe wt_mult_pipe_chk #(.WIDTH(WIDTH), .LAT(wt_pkg::wt_levels(WIDTH))) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_vld(op_vld),
  .prod(prod), .prod_vld(prod_vld)
);

// File: tb/wt_mult_pipe_test.sv
module wt_mult_pipe_test;

  localparam int LAT8 = 4;  // R2: 8,6,4,3,2
  localparam int LAT4 = 2;  // R2: 4,3,2

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rst_n;
  logic [7:0]  a8, b8;
  logic        v8;
  logic [15:0] p8;
  logic        pv8;
  logic [3:0]  a4, b4;
  logic        v4;
  logic [7:0]  p4;
  logic        pv4;

  int checks = 0;
  int bad = 0;
  logic chk_on = 1'b0;

  wt_mult_pipe #(.WIDTH(8)) uut (
    .clk(clk), .rst_n(rst_n), .op_a(a8), .op_b(b8), .op_vld(v8),
    .prod(p8), .prod_vld(pv8)
  );

  wt_mult_pipe #(.WIDTH(4)) uut_narrow (
    .clk(clk), .rst_n(rst_n), .op_a(a4), .op_b(b4), .op_vld(v4),
    .prod(p4), .prod_vld(pv4)
  );

  // bench-side delay lines for expected values
  logic [7:0] ha8 [LAT8];
  logic [7:0] hb8 [LAT8];
  logic       hv8 [LAT8];
  logic [3:0] ha4 [LAT4];
  logic [3:0] hb4 [LAT4];
  logic       hv4 [LAT4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT8; i++) hv8[i] <= 1'b0;
      for (int i = 0; i < LAT4; i++) hv4[i] <= 1'b0;
    end else begin
      ha8[0] <= a8; hb8[0] <= b8; hv8[0] <= v8;
      for (int i = 1; i < LAT8; i++) begin
        ha8[i] <= ha8[i-1]; hb8[i] <= hb8[i-1]; hv8[i] <= hv8[i-1];
      end
      ha4[0] <= a4; hb4[0] <= b4; hv4[0] <= v4;
      for (int i = 1; i < LAT4; i++) begin
        ha4[i] <= ha4[i-1]; hb4[i] <= hb4[i-1]; hv4[i] <= hv4[i-1];
      end
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // R6 literal expectations
  function automatic logic dir_hit(input logic [7:0] a, input logic [7:0] b, output logic [15:0] e);
    dir_hit = 1'b1;
    if      (a == 8'h0F && b == 8'hFA) e = 16'h0EA6;
    else if (a == 8'hF0 && b == 8'hFF) e = 16'hEF10;
    else if (a == 8'h5A && b == 8'hF0) e = 16'h5460;
    else if (a == 8'h00 && b == 8'hF0) e = 16'h0000;
    else begin e = 16'h0; dir_hit = 1'b0; end
  endfunction

  // stream checker: output after each edge vs. input LAT edges before
  always @(negedge clk) begin
    logic [15:0] e8, d8;
    logic [7:0]  e4;
    if (rst_n && chk_on) begin
      // R3 valid follows valid
      check(pv8 === hv8[LAT8-1], "R3 w8 valid", longint'(pv8), longint'(hv8[LAT8-1]));
      check(pv4 === hv4[LAT4-1], "R3 w4 valid", longint'(pv4), longint'(hv4[LAT4-1]));
      if (hv8[LAT8-1]) begin
        e8 = 16'(ha8[LAT8-1]) * 16'(hb8[LAT8-1]);
        // R1 R4: in-order product of a back-to-back stream
        if (ha8[LAT8-1] == 8'h00 || hb8[LAT8-1] == 8'h00 || (ha8[LAT8-1] == 8'hFF && hb8[LAT8-1] == 8'hFF))
          check(p8 === e8, "R7 w8 product", longint'(p8), longint'(e8));
        else
          check(p8 === e8, "R1 R4 w8 product", longint'(p8), longint'(e8));
        if (dir_hit(ha8[LAT8-1], hb8[LAT8-1], d8))
          check(p8 === d8, "R6 w8 vector", longint'(p8), longint'(d8));
      end
      if (hv4[LAT4-1]) begin
        e4 = 8'(ha4[LAT4-1]) * 8'(hb4[LAT4-1]);
        check(p4 === e4, "R1 R4 w4 product", longint'(p4), longint'(e4));
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0;
    a8 = '0; b8 = '0; v8 = 1'b0;
    a4 = '0; b4 = '0; v4 = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      // R5 outputs quiet in reset
      check(pv8 === 1'b0 && pv4 === 1'b0, "R5 reset valid", longint'({pv8, pv4}), 0);
    end
    rst_n = 1'b1;
    chk_on = 1'b1;
    repeat (3) @(negedge clk);

    // R2 latency of the wide copy
    a8 = 8'h33; b8 = 8'h11; v8 = 1'b1;
    @(negedge clk);
    v8 = 1'b0;
    n = 1;
    while (!pv8 && n < 20) begin @(negedge clk); n++; end
    check(n == LAT8, "R2 w8 latency", longint'(n), longint'(LAT8));
    repeat (4) @(negedge clk);

    // R2 latency of the narrow copy
    a4 = 4'h5; b4 = 4'h3; v4 = 1'b1;
    @(negedge clk);
    v4 = 1'b0;
    n = 1;
    while (!pv4 && n < 20) begin @(negedge clk); n++; end
    check(n == LAT4, "R2 w4 latency", longint'(n), longint'(LAT4));
    repeat (4) @(negedge clk);

    // R6 R7 directed vectors back to back; narrow copy swept exhaustively without gaps
    for (int i = 0; i < 256; i++) begin
      case (i)
        0: begin a8 = 8'h0F; b8 = 8'hFA; end
        1: begin a8 = 8'hF0; b8 = 8'hFF; end
        2: begin a8 = 8'h5A; b8 = 8'hF0; end
        3: begin a8 = 8'h00; b8 = 8'hF0; end
        4: begin a8 = 8'hFF; b8 = 8'hFF; end
        5: begin a8 = 8'h00; b8 = 8'h00; end
        default: begin a8 = 8'(i * 37); b8 = 8'(i * 11 + 5); end
      endcase
      v8 = (i < 6) || (i % 3 == 0);
      a4 = i[7:4]; b4 = i[3:0]; v4 = 1'b1;
      @(negedge clk);
    end

    // R1 R4 exhaustive wide sweep; narrow copy again with bubbles (R3)
    for (int i = 0; i < 65536; i++) begin
      a8 = i[15:8]; b8 = i[7:0]; v8 = 1'b1;
      a4 = i[7:4];  b4 = i[3:0]; v4 = (i % 5) != 2;
      @(negedge clk);
    end

    // R5 reset in the middle of a full pipeline
    for (int i = 0; i < 6; i++) begin
      a8 = 8'(i + 200); b8 = 8'(i + 3); v8 = 1'b1;
      a4 = 4'(i + 9);   b4 = 4'(i + 1); v4 = 1'b1;
      @(negedge clk);
    end
    rst_n = 1'b0;
    #1;
    check(pv8 === 1'b0 && pv4 === 1'b0, "R5 async clear", longint'({pv8, pv4}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    v8 = 1'b0; v4 = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(pv8 === 1'b0 && pv4 === 1'b0, "R5 flushed", longint'({pv8, pv4}), 0);
    end

    // drain
    repeat (8) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule